// File: doc/BRIEF.md
# I2C Slave Read-Data Server

This block is the transmit half of an I2C slave. Once the surrounding logic has matched the address of a read transfer, it pulses `rd_begin`. The block then takes a byte from a local ready/valid source and shifts it onto SDA, MSB first. It places each bit while SCL is low and holds it through the following SCL high phase. SDA is open-drain, so the block never drives a one. It asserts `sda_pull` to pull the line low and otherwise leaves it floating.

After the eighth bit the block lets go of SDA and reads the master's response in the ninth clock. A low response (ACK) makes it fetch another byte and keep serving. A high response (NAK) ends the transfer: the block stays off the line so that the master can produce STOP, and it raises `xfer_end` for one cycle. A START or STOP seen on the bus while the block is serving returns it to idle at once.

Both bus inputs pass through a synchroniser, and every decision uses edges detected on the synchronised levels.

Top module: `i2c_rd_server`

## Requirements
- R1: During and right after reset, `sda_pull`, `src_take`, `busy` and `xfer_end` are all low.
- R2: A served byte appears on the bus MSB first, one bit per SCL clock; a one leaves SDA released and a zero asserts `sda_pull`.
- R3: The value on SDA stays fixed for the whole of each SCL high phase while a byte is being sent.
- R4: Once the SCL falling edge that closes the eighth bit has been seen, `sda_pull` is low for the entire ninth clock.
- R5: If SDA is low when SCL rises in the ninth clock, the block takes another byte from the source after that clock's falling edge and drives its MSB during the same SCL low phase; `rd_begin` also causes one take.
- R6: If SDA is high when SCL rises in the ninth clock, `xfer_end` pulses for one cycle, `busy` drops, and SDA stays released with no further take until the next `rd_begin`.
- R7: A START (SDA falling with SCL high) or STOP (SDA rising with SCL high) returns the block to idle with SDA released, and wins over an `rd_begin` that arrives in the same cycle.
- R8: `src_take` is high for exactly one clock cycle per byte taken; a byte is consumed from the source only when `src_valid` is high in that cycle.
- R9: If `src_valid` is low when a byte is taken, the byte sent is 0xFF, so SDA stays released for all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired bus value) |
| sda_pull | output | 1 | When high, the block pulls SDA low |
| rd_begin | input | 1 | One-cycle pulse, given while SCL is low, that starts serving a read |
| src_valid | input | 1 | Source has a byte on `src_data` |
| src_data | input | DATA_W | Byte offered by the source |
| src_take | output | 1 | One-cycle pulse: the byte on `src_data` is consumed this cycle |
| busy | output | 1 | High while a read is being served |
| xfer_end | output | 1 | One-cycle pulse when the master NAKs |

## Verification
Two things can land in the same cycle: a bus condition (STOP) detected on the synchronised lines and a new `rd_begin` pulse. The bench counts the synchroniser stages from the clock edge where it raises SDA with SCL high, and it raises `rd_begin` so that both are seen at the same edge. The outcome is judged at the ports. `busy` must stay low, no take may happen, and `sda_pull` must stay low for the cycles that follow.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_ACKWAIT,
        ST_ACKHOLD
    } srv_state_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic ok, input logic [BYTE_W-1:0] d);
        return ok ? d : {BYTE_W{1'b1}};
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync
    import i2c_rd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output line_ev_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ev.lvl  = chain[STAGES-1];
        ev.rise = chain[STAGES-1] & ~prev;
        ev.fall = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/bus_cond.sv
module bus_cond
    import i2c_rd_pkg::*;
(
    input  line_ev_t scl_ev,
    input  line_ev_t sda_ev,
    output logic     start_det,
    output logic     stop_det
);
    logic scl_steady_hi;

    always_comb begin
        scl_steady_hi = scl_ev.lvl & ~scl_ev.rise;
        start_det     = scl_steady_hi & sda_ev.fall;
        stop_det      = scl_steady_hi & sda_ev.rise;
    end
endmodule

// File: rtl/tx_shift.sv
module tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '1;
            cnt <= '0;
        end else if (load) begin
            sh  <= load_val;
            cnt <= CW'(W - 1);
        end else if (shift) begin
            sh  <= {sh[W-2:0], 1'b1};
            cnt <= cnt - 1'b1;
        end
    end

    assign msb  = sh[W-1];
    assign last = (cnt == '0);
endmodule

// File: rtl/i2c_rd_server.sv
module i2c_rd_server
    import i2c_rd_pkg::*;
#(
    parameter int DATA_W      = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              rd_begin,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_take,
    output logic              busy,
    output logic              xfer_end
);
    line_ev_t   scl_ev, sda_ev;
    logic       start_det, stop_det, bus_abort;
    logic       scl_lvl;
    logic       sh_load, sh_shift, sh_msb, sh_last;
    srv_state_e state;

    line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_in), .ev(scl_ev)
    );
    line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_in), .ev(sda_ev)
    );

    bus_cond u_cond (
        .scl_ev(scl_ev), .sda_ev(sda_ev),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign bus_abort = start_det | stop_det;
    assign scl_lvl   = scl_ev.lvl;

    assign sh_load  = (state == ST_FETCH);
    assign sh_shift = (state == ST_SEND) & scl_ev.fall & ~sh_last & ~bus_abort;

    tx_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst(rst),
        .load(sh_load),
        .load_val(DATA_W'(pick_byte(src_valid, BYTE_W'(src_data)))),
        .shift(sh_shift),
        .msb(sh_msb), .last(sh_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            xfer_end <= 1'b0;
        end else begin
            xfer_end <= 1'b0;
            if (bus_abort) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE:    if (rd_begin) state <= ST_FETCH;
                    ST_FETCH:   state <= ST_SEND;
                    ST_SEND:    if (scl_ev.fall && sh_last) state <= ST_ACKWAIT;
                    ST_ACKWAIT: if (scl_ev.rise) begin
                                    if (sda_ev.lvl) begin
                                        state    <= ST_IDLE;
                                        xfer_end <= 1'b1;
                                    end else begin
                                        state <= ST_ACKHOLD;
                                    end
                                end
                    ST_ACKHOLD: if (scl_ev.fall) state <= ST_FETCH;
                    default:    state <= ST_IDLE;
                endcase
            end
        end
    end

    assign src_take = (state == ST_FETCH);
    assign sda_pull = (state == ST_SEND) & ~sh_msb;
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/i2c_rd_server_chk.sv
module i2c_rd_server_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic bus_abort,
    input logic rd_begin,
    input logic sda_pull,
    input logic src_take,
    input logic busy,
    input logic xfer_end
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_pull && !src_take && !busy && !xfer_end));

    a_r3_hold_high: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl) && !$past(bus_abort) && !$past(rd_begin)) |-> $stable(sda_pull));

    a_r6_nak_release: assert property (@(posedge clk) disable iff (rst)
        xfer_end |-> (!sda_pull && !busy && !src_take));

    a_r7_abort_idle: assert property (@(posedge clk) disable iff (rst)
        bus_abort |=> (!busy && !sda_pull));

    a_r8_take_pulse: assert property (@(posedge clk) disable iff (rst)
        src_take |=> !src_take);
endmodule

bind i2c_rd_server i2c_rd_server_chk u_chk (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .bus_abort(bus_abort),
    .rd_begin(rd_begin), .sda_pull(sda_pull), .src_take(src_take),
    .busy(busy), .xfer_end(xfer_end)
);

// File: tb/i2c_rd_server_bench.sv
module i2c_rd_server_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_pull = 1'b0;
    logic       rd_begin = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] pool [64];
    int         idx = 0;
    logic       sda_line;
    logic       sda_pull, src_take, busy, xfer_end;

    int n_tests = 0, n_fail = 0;
    int take_cnt = 0, end_cnt = 0, run = 0, max_run = 0;
    int eidx = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    assign sda_line = ~(sda_pull | m_pull);

    i2c_rd_server u_i2c_rd_server (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .rd_begin(rd_begin),
        .src_valid(src_valid), .src_data(pool[idx]),
        .src_take(src_take), .busy(busy), .xfer_end(xfer_end)
    );

    // source: consume on take with valid
    always @(posedge clk) if (!rst && src_take && src_valid) idx <= (idx + 1) % 64;

    always @(negedge clk) begin
        if (!rst) begin
            if (src_take) begin take_cnt++; run++; end else run = 0;
            if (run > max_run) max_run = run;
            if (xfer_end) end_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input bit v);
        logic [7:0] b;
        if (v) begin b = pool[eidx]; eidx = (eidx + 1) % 64; end
        else b = 8'hFF;
        return b;
    endfunction

    // one byte plus ninth clock; SCL low on entry and exit
    task automatic read_byte(input bit ack, input logic [7:0] exp);
        logic [7:0] got;
        bit stable_ok = 1;
        bit rel_ok = 1;
        logic s0, s1;
        for (int i = 7; i >= 0; i--) begin
            waitn(HALF);
            scl = 1'b1;
            waitn(2); s0 = sda_line;
            waitn(4); s1 = sda_line;
            waitn(2);
            scl = 1'b0;
            got[i] = s0;
            if (s0 !== s1) stable_ok = 0;
        end
        waitn(5);
        if (sda_pull !== 1'b0) rel_ok = 0;
        m_pull = ack;
        waitn(3);
        scl = 1'b1;
        for (int k = 0; k < HALF; k++) begin
            waitn(1);
            if (sda_pull !== 1'b0) rel_ok = 0;
        end
        scl = 1'b0;
        waitn(4);
        m_pull = 1'b0;
        check(got === exp, "R2 byte shifted MSB first", got, exp);
        check(stable_ok, "R3 SDA steady during SCL high", stable_ok, 1);
        check(rel_ok, "R4 SDA released in ninth clock", rel_ok, 1);
    endtask

    task automatic bus_start_low();
        m_pull = 1'b1; waitn(4);
        scl = 1'b0;    waitn(3);
        m_pull = 1'b0; waitn(4);
    endtask

    task automatic bus_stop();
        waitn(4); m_pull = 1'b1;
        waitn(4); scl = 1'b1;
        waitn(4); m_pull = 1'b0;
        waitn(6);
    endtask

    task automatic do_read(input int nbytes, input bit v);
        int t0, e0;
        t0 = take_cnt; e0 = end_cnt;
        src_valid = v;
        bus_start_low();
        rd_begin = 1'b1; waitn(1); rd_begin = 1'b0;
        for (int b = 0; b < nbytes; b++)
            read_byte(b != nbytes - 1, exp_byte(v));
        check(take_cnt - t0 == nbytes, "R5 one take per served byte", take_cnt - t0, nbytes);
        check(end_cnt - e0 == 1, "R6 end pulse on NAK", end_cnt - e0, 1);
        check(!busy && !sda_pull, "R6 idle and released after NAK", {busy, sda_pull}, 0);
        bus_stop();
        check(take_cnt - t0 == nbytes, "R6 no take after NAK", take_cnt - t0, nbytes);
    endtask

    initial begin
        int t0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) pool[i] = 8'($urandom);
        pool[0] = 8'h00; pool[1] = 8'hA5; pool[2] = 8'h7E;
        waitn(5);
        check(!sda_pull && !src_take && !busy && !xfer_end, "R1 reset outputs",
              {sda_pull, src_take, busy, xfer_end}, 0);
        rst = 1'b0;
        waitn(5);
        check(!sda_pull && !busy, "R1 idle after reset", {sda_pull, busy}, 0);

        // directed: three bytes ACK, ACK, NAK
        do_read(3, 1'b1);
        // empty source gives 0xFF
        t0 = idx;
        do_read(1, 1'b0);
        check(idx == t0, "R9 nothing consumed when source empty", idx, t0);
        check(max_run == 1, "R8 take is a single-cycle pulse", max_run, 1);

        // random transactions
        for (int n = 0; n < 8; n++) do_read(1 + int'($urandom % 4), 1'($urandom % 4 != 0));

        // R7 abort with START in the middle of an all-ones byte
        src_valid = 1'b0;
        bus_start_low();
        rd_begin = 1'b1; waitn(1); rd_begin = 1'b0;
        waitn(HALF);
        scl = 1'b1; waitn(4);
        m_pull = 1'b1; waitn(6);
        check(!busy && !sda_pull, "R7 START returns to idle", {busy, sda_pull}, 0);
        scl = 1'b0; waitn(4);
        m_pull = 1'b0; waitn(4);
        scl = 1'b1; waitn(6);

        // R7 STOP and rd_begin seen at the same edge
        m_pull = 1'b1; waitn(6);
        t0 = take_cnt;
        m_pull = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk) rd_begin = 1'b1;
        @(negedge clk) rd_begin = 1'b0;
        waitn(4);
        check(!busy && !sda_pull, "R7 STOP wins over same-cycle begin", {busy, sda_pull}, 0);
        check(take_cnt == t0, "R7 no take on collided begin", take_cnt - t0, 0);

        // after abort a normal read still works
        do_read(2, 1'b1);
        check(max_run == 1, "R8 take pulses stay single-cycle", max_run, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule